// File: doc/BRIEF.md
# Toggle-Kick Output Watchdog

This block guards a bank of digital outputs with a global output-enable. Software turns the outputs on through a global enable bit, arms the watchdog, and chooses a timeout from five periods (125 ms, 250 ms, 500 ms, 1 s, 2 s). To keep the outputs alive, software must write bit 0 of a trigger register with alternating values. Each write that flips the stored bit restarts the timer. A write that repeats the stored value does not restart it.

Each alternating write must arrive within one quarter of the selected period. A prescaler turns the system clock into a quarter-millisecond tick, so the deadline in ticks equals the period in milliseconds. When the deadline passes, a sticky timeout flag is set. The flag forces the outputs off and, if enabled, raises an interrupt. Software reads and clears the flag through the same small register bus. The parameter `QTR_CYC` sets how many clock cycles form one tick, which lets a simulation use a scaled time base.

Top module: `toggle_wdog`

## Requirements
- R1: After reset every register field, the stored trigger bit and the timeout flag are 0, so `out_en`, `irq` and `data_out` are all low.
- R2: A write to address 0 loads the control fields. These are bit 0 global output enable, bit 1 watchdog enable, bit 2 interrupt enable, and bits 5:3 period code. Reading address 0 returns the same layout. Reading address 3 returns 0.
- R3: Period codes 0, 1, 2, 3 and 4 give deadlines of 125, 250, 500, 1000 and 2000 ticks. Codes 5 to 7 give 2000 ticks. Each tick is `QTR_CYC` clock cycles. The timeout flag is set exactly deadline × `QTR_CYC` cycles after the clock edge that restarted the timer.
- R4: A write to address 1 whose bit 0 differs from the stored trigger bit is a valid kick. It stores the new bit, which reads back as bit 0 of address 1, and it restarts the timer.
- R5: A write to address 1 whose bit 0 equals the stored trigger bit has no effect. The stored bit does not change and the timer does not restart.
- R6: Changing the watchdog enable from 0 to 1 restarts the timer. Rewriting control with the enable already set does not restart it.
- R7: While the watchdog enable is 0, no timeout occurs and the outputs follow the global output enable alone.
- R8: The timeout flag, read as bit 0 of address 2, stays set until a write to address 2 with bit 0 = 1. A write with bit 0 = 0 leaves it unchanged. A timeout in the same cycle as a clear leaves the flag set. While the flag is set the timer is held, and a fresh deadline starts after the flag is cleared.
- R9: `out_en` = global output enable AND NOT timeout flag. `data_out` equals `data_in` when `out_en` is 1 and is 0 otherwise.
- R10: `irq` = interrupt enable AND timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 2 | Register address (0 control, 1 trigger, 2 status, 3 reserved) |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data for `bus_addr`, combinational |
| data_in | input | NOUT | Output values requested by logic |
| data_out | output | NOUT | Gated output values |
| out_en | output | 1 | Global output enable after watchdog gating |
| irq | output | 1 | Timeout interrupt |

## Verification
The checker watches every cycle for the following:
- The timeout flag stays set until a clearing write arrives.
- The flag is set only by the timer's expiry event.
- Expiry never occurs while the watchdog is disarmed.
- A set flag always blocks `out_en`.
- `irq` never appears without the flag.
- A valid kick always flips the stored bit, and a same-value trigger write leaves it alone.

The exact deadline in cycles for each period code needs the bench's scenarios. So do the distinction between a toggle and a repeated write as seen at the timeout instant, and the rule that re-arming while armed does not restart the timer. The behavioural model compares against these scenarios every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned DW    = 6;
  localparam int unsigned WIN_W = 11;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_KICK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic [2:0] per;
    logic       irq_en;
    logic       wd_en;
    logic       goe;
  } ctrl_t;

  // Deadline in quarter-millisecond ticks; equals the period in ms / 4 * 4.
  function automatic logic [WIN_W-1:0] win_ticks(input logic [2:0] code);
    case (code)
      3'd0:    return WIN_W'(125);
      3'd1:    return WIN_W'(250);
      3'd2:    return WIN_W'(500);
      3'd3:    return WIN_W'(1000);
      default: return WIN_W'(2000);
    endcase
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          expire,
  output ctrl_t         ctrl,
  output logic          status,
  output logic          last_kick,
  output logic          kick_ok,
  output logic          wd_start,
  output logic [DW-1:0] rdata
);

  logic  wr_ctrl, wr_kick, wr_stat;
  ctrl_t ctrl_nxt;

  assign wr_ctrl  = bus_sel & bus_we & (bus_addr == A_CTRL);
  assign wr_kick  = bus_sel & bus_we & (bus_addr == A_KICK);
  assign wr_stat  = bus_sel & bus_we & (bus_addr == A_STAT);
  assign ctrl_nxt = ctrl_t'(bus_wdata);

  // Only a change of the trigger bit counts as a kick
  assign kick_ok  = wr_kick & (bus_wdata[0] != last_kick);
  // Arming edge of the watchdog
  assign wd_start = wr_ctrl & ctrl_nxt.wd_en & ~ctrl.wd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      status    <= 1'b0;
      last_kick <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_nxt;
      if (kick_ok) last_kick <= bus_wdata[0];
      if (expire)
        status <= 1'b1;
      else if (wr_stat && bus_wdata[0])
        status <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  rdata = ctrl;
      A_KICK:  rdata = {{(DW-1){1'b0}}, last_kick};
      A_STAT:  rdata = {{(DW-1){1'b0}}, status};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned QTR_CYC = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [WIN_W-1:0] lim,
  output logic             tick,
  output logic             expire
);

  localparam int unsigned    PRE_W    = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(QTR_CYC - 1);

  logic [PRE_W-1:0] pre;
  logic [WIN_W-1:0] cnt;

  assign tick   = run & (pre == PRE_LAST);
  assign expire = tick & ~restart & (cnt >= lim - WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (!run || restart) begin
      pre <= '0;
      cnt <= '0;
    end else if (tick) begin
      pre <= '0;
      cnt <= cnt + WIN_W'(1);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

endmodule

// File: rtl/wdt_gate.sv
module wdt_gate #(
  parameter int unsigned NOUT = 8
) (
  input  logic            goe,
  input  logic            status,
  input  logic            irq_en,
  input  logic [NOUT-1:0] data_in,
  output logic [NOUT-1:0] data_out,
  output logic            out_en,
  output logic            irq
);

  assign out_en = goe & ~status;
  assign irq    = irq_en & status;

  for (genvar g = 0; g < NOUT; g++) begin : g_bit
    assign data_out[g] = data_in[g] & out_en;
  end

endmodule

// File: rtl/toggle_wdog.sv
module toggle_wdog
  import wdt_pkg::*;
#(
  parameter int unsigned NOUT    = 8,
  parameter int unsigned QTR_CYC = 12500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NOUT-1:0] data_in,
  output logic [NOUT-1:0] data_out,
  output logic            out_en,
  output logic            irq
);

  ctrl_t            ctrl;
  logic             status_q, last_kick, kick_ok, wd_start;
  logic             run, restart, tick, expire;
  logic [WIN_W-1:0] lim;

  assign run     = ctrl.wd_en & ~status_q;
  assign restart = kick_ok | wd_start;
  assign lim     = win_ticks(ctrl.per);

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .expire(expire), .ctrl(ctrl), .status(status_q), .last_kick(last_kick),
    .kick_ok(kick_ok), .wd_start(wd_start), .rdata(bus_rdata)
  );

  wdt_timer #(.QTR_CYC(QTR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .lim(lim),
    .tick(tick), .expire(expire)
  );

  wdt_gate #(.NOUT(NOUT)) u_gate (
    .goe(ctrl.goe), .status(status_q), .irq_en(ctrl.irq_en),
    .data_in(data_in), .data_out(data_out), .out_en(out_en), .irq(irq)
  );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          status,
  input logic          expire,
  input logic          tick,
  input logic          kick_ok,
  input logic          last_kick,
  input logic          wd_en,
  input logic          goe,
  input logic          out_en,
  input logic          irq
);

  logic clr_wr, kick_wr;
  assign clr_wr  = bus_sel & bus_we & (bus_addr == A_STAT) & bus_wdata[0];
  assign kick_wr = bus_sel & bus_we & (bus_addr == A_KICK);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_wr) |=> status);

  // R8
  set_by_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !expire) |=> !status);

  // R3
  expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);

  // R7
  no_expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> !expire);

  // R9
  oe_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> !out_en);

  // R9
  oe_needs_goe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> goe);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);

  // R4
  kick_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (last_kick != $past(last_kick)));

  // R5
  same_kick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_wr && (bus_wdata[0] == last_kick)) |=> $stable(last_kick));

endmodule

bind toggle_wdog wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .status(status_q), .expire(expire), .tick(tick), .kick_ok(kick_ok),
  .last_kick(last_kick), .wd_en(ctrl.wd_en), .goe(ctrl.goe),
  .out_en(out_en), .irq(irq)
);

// File: tb/toggle_wdog_bench.sv
`timescale 1ns/1ps
module toggle_wdog_bench;

  localparam int NOUT = 8;
  localparam int Q    = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]      bus_addr = 2'd0;
  logic [5:0]      bus_wdata = 6'd0;
  logic [5:0]      bus_rdata;
  logic [NOUT-1:0] data_in = '0, data_out;
  logic            out_en, irq;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  toggle_wdog #(.NOUT(NOUT), .QTR_CYC(Q)) u_toggle_wdog (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_in(data_in), .data_out(data_out), .out_en(out_en), .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_goe, m_en, m_ie, m_per, m_last, m_stat, m_cnt;

  function automatic int win_of(int p);
    if (p == 0) return 125;
    if (p == 1) return 250;
    if (p == 2) return 500;
    if (p == 3) return 1000;
    return 2000;
  endfunction

  task automatic cmp(int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit wr, kick, start, run, expire;
    int nc, e_oe, e_rd;
    if (!rst_n) begin
      m_goe = 0; m_en = 0; m_ie = 0; m_per = 0; m_last = 0; m_stat = 0; m_cnt = 0;
    end else begin
      wr     = bus_sel && bus_we;
      kick   = wr && bus_addr == 2'd1 && int'(bus_wdata[0]) != m_last;
      start  = wr && bus_addr == 2'd0 && bus_wdata[1] && m_en == 0;
      run    = m_en != 0 && m_stat == 0;
      expire = 0;
      if (!run || kick || start) nc = 0;
      else begin
        nc = m_cnt + 1;
        expire = (nc % Q == 0) && (nc >= win_of(m_per) * Q);
      end
      m_cnt = nc;
      if (wr && bus_addr == 2'd0) begin
        m_goe = bus_wdata[0]; m_en = bus_wdata[1]; m_ie = bus_wdata[2];
        m_per = int'(bus_wdata[5:3]);
      end
      if (kick) m_last = bus_wdata[0];
      if (expire) m_stat = 1;
      else if (wr && bus_addr == 2'd2 && bus_wdata[0]) m_stat = 0;
    end
    #1;
    e_oe = (m_goe != 0 && m_stat == 0) ? 1 : 0;
    case (bus_addr)
      2'd0:    e_rd = m_goe | (m_en << 1) | (m_ie << 2) | (m_per << 3);
      2'd1:    e_rd = m_last;
      2'd2:    e_rd = m_stat;
      default: e_rd = 0;
    endcase
    cmp(int'(out_en), e_oe, "R9 out_en");
    cmp(int'(irq), (m_ie != 0 && m_stat != 0) ? 1 : 0, "R10 irq");
    cmp(int'(data_out), e_oe != 0 ? int'(data_in) : 0, "R9 data_out");
    cmp(int'(bus_rdata), e_rd, "R2 rdata");
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    cmp(int'(out_en), 0, "R1 out_en in reset");
    cmp(int'(irq), 0, "R1 irq in reset");
    cmp(int'(bus_rdata), 0, "R1 ctrl in reset");
    rst_n = 1'b1;
    data_in = 8'hA5;
    idle(2);

    // R2 / R7: outputs on, watchdog disarmed, long wait, no timeout
    wr(2'd0, 6'h01);
    idle(600);
    cmp(int'(out_en), 1, "R7 out_en with watchdog off");
    cmp(int'(data_out), 8'hA5, "R9 data passes");
    bus_addr = 2'd3; idle(1);
    cmp(int'(bus_rdata), 0, "R2 reserved address reads zero");

    // R6 / R4: arm with period code 0 (250 cycles), keep kicking
    wr(2'd0, 6'h07);
    bus_addr = 2'd0; idle(1);
    cmp(int'(bus_rdata), 6'h07, "R2 ctrl readback");
    idle(150); wr(2'd1, 6'h01);
    idle(200); wr(2'd1, 6'h00);
    idle(200); wr(2'd1, 6'h01);
    idle(200); wr(2'd1, 6'h00);
    bus_addr = 2'd1;
    cmp(int'(irq), 0, "R4 toggling keeps watchdog alive");
    cmp(int'(bus_rdata), 0, "R4 stored trigger bit");
    // R5: repeated value does not restart; timeout 250 after last toggle
    idle(100); wr(2'd1, 6'h00);
    cmp(int'(bus_rdata), 0, "R5 stored bit unchanged");
    idle(147);
    cmp(int'(irq), 0, "R3 one cycle before deadline");
    idle(1);
    cmp(int'(irq), 1, "R5 repeated write did not restart, timeout at deadline");
    cmp(int'(out_en), 0, "R9 outputs forced off");
    cmp(int'(data_out), 0, "R9 data blocked");

    // R8: writing 0 does not clear; flag holds
    wr(2'd2, 6'h00);
    idle(50);
    cmp(int'(irq), 1, "R8 write of 0 leaves flag set");
    bus_addr = 2'd2; idle(1);
    cmp(int'(bus_rdata), 1, "R8 status readback");
    // R8 / R6: clear, then rewrite ctrl while armed: no restart
    wr(2'd2, 6'h01);
    cmp(int'(irq), 0, "R8 cleared");
    wr(2'd0, 6'h07);
    idle(247);
    cmp(int'(irq), 0, "R6 before deadline after clear");
    idle(1);
    cmp(int'(irq), 1, "R6 rewrite while armed did not restart");

    // R10: interrupt disabled masks irq but not the flag
    wr(2'd0, 6'h03);
    cmp(int'(irq), 0, "R10 irq masked");
    cmp(int'(out_en), 0, "R9 flag still blocks outputs");

    // R6 / R3: disarm, clear, arm with code 1 (500 cycles)
    data_in = 8'h3C;
    wr(2'd0, 6'h01);
    wr(2'd2, 6'h01);
    cmp(int'(out_en), 1, "R7 outputs follow enable when disarmed");
    wr(2'd0, 6'h0F);
    idle(499);
    cmp(int'(irq), 0, "R3 code 1 before deadline");
    idle(1);
    cmp(int'(irq), 1, "R3 code 1 deadline");

    // R3: code 7 maps to 2000 ticks (4000 cycles)
    wr(2'd0, 6'h01);
    wr(2'd2, 6'h01);
    wr(2'd0, 6'h3F);
    idle(3999);
    cmp(int'(irq), 0, "R3 code 7 before deadline");
    idle(1);
    cmp(int'(irq), 1, "R3 code 7 deadline");

    // R8: clear landing on the expiry edge keeps the flag
    wr(2'd0, 6'h01);
    wr(2'd2, 6'h01);
    wr(2'd0, 6'h07);
    idle(248);
    wr(2'd2, 6'h01);
    cmp(int'(irq), 1, "R8 timeout wins over simultaneous clear");

    idle(5);
    summary();
    $finish;
  end

endmodule